// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks up one address translation in a hashed page table kept in memory. A caller gives a segment identifier, a 16-bit page index, the table base address and a table size mask. The block hashes the segment identifier with the page index and uses the hash to select one 64-byte group of eight 8-byte entries. It then reads that group one entry at a time over a plain read request/response port. Only one read is in flight at a time.

Each returned entry is compared against the wanted tag. The search stops at the first matching entry, and the block reports a hit together with the physical page number. If none of the eight entries in the primary group match, the block searches a secondary group addressed by the complemented hash. If that group also has no match, it reports a miss.

The table is a power of two in size and is aligned to its own size. This lets the masked hash be ORed straight into the base address. The block keeps no status other than the busy flag and the done pulse.

Top module: `pteg_walker`

## Requirements
- R1: The primary hash is bits 18:0 of the segment identifier XOR the 16-bit page index zero-extended to 19 bits. The secondary hash is the bitwise complement of the primary hash.
- R2: Every read address equals `tbl_base | ((hash & tbl_mask) << 6) | (entry_index << 3)`. Here `entry_index` runs from 0 to 7 within the group. `tbl_base` and `tbl_mask` are the values captured when the request was accepted.
- R3: The entries of a group are read in ascending address order. A new read is issued only after the response to the previous one has arrived, so at most one read is outstanding.
- R4: An entry matches only if all of these hold:
  - its valid bit (bit 63) is 1;
  - its hash-select bit (bit 38) equals the current pass, 0 for primary and 1 for secondary;
  - its segment field (bits 62:39) equals the requested segment identifier;
  - its abbreviated index field (bits 37:32) equals page index bits 15:10.
- R5: The first matching entry ends the search. `done` and `hit` are then asserted together, and `hit_rpn` carries bits 31:12 of that entry. No further reads are issued.
- R6: After all eight primary entries fail to match, the block searches the group addressed by the secondary hash, starting at entry 0.
- R7: After all eight secondary entries also fail to match, the block asserts `done` with `hit` low. The search has then made exactly sixteen reads.
- R8: `req_valid` is accepted only while `busy` is low. A request presented while a search is running is ignored entirely.
- R9: After reset, `busy`, `rd_req` and `done` are low.
- R10: `done` is a single-cycle pulse in the cycle after the final read response. At the same time `busy` drops. `hit` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a search (taken only while idle) |
| req_vsid | input | 24 | Segment identifier to look up |
| req_pidx | input | 16 | Page index within the segment |
| tbl_base | input | 32 | Table base address, aligned to the table size |
| tbl_mask | input | 19 | Table size mask applied to the hash |
| busy | output | 1 | Search in progress |
| rd_req | output | 1 | One-cycle memory read request |
| rd_addr | output | 32 | Byte address of the entry to read |
| rd_rsp_valid | input | 1 | Read data is valid this cycle |
| rd_rsp_data | input | 64 | Returned 8-byte table entry |
| done | output | 1 | Search finished (one-cycle pulse) |
| hit | output | 1 | Search found a match (valid with done) |
| hit_rpn | output | 20 | Physical page number of the match |

## Verification
The bench uses several kinds of decoy entries ahead of the real match. These are:
- an invalid entry with the right tag;
- a valid entry with the wrong hash-select bit;
- an entry whose abbreviated index differs.

A comparator that skipped any single field would stop early and report the wrong page number. Groups holding two matches confirm that the lower address wins; a descending scan or a last-match latch would return the later one. A secondary-pass case and a sixteen-read miss expose a design that forgets to complement the hash, restarts at the wrong entry, or ends after one group. Varied response latency, a narrow mask, and a request pulsed mid-search catch extra reads, stale address capture, and a busy block that accepts new work.

// File: rtl/pteg_walker_pkg.sv
package pteg_walker_pkg;
   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_ISSUE = 2'd1,
      WS_WAIT  = 2'd2
   } walk_state_t;

   localparam int unsigned ENTRY_W     = 64;
   localparam int unsigned ENTRY_SHIFT = 3;
endpackage

// File: rtl/pteg_hash.sv
module pteg_hash #(
   parameter int unsigned VSID_W = 24,
   parameter int unsigned PIDX_W = 16,
   parameter int unsigned HASH_W = 19
) (
   input  logic [VSID_W-1:0] vsid,
   input  logic [PIDX_W-1:0] pidx,
   input  logic              secondary,
   output logic [HASH_W-1:0] hash
);
   if (HASH_W < PIDX_W) begin : g_bad_width
      $error("hash narrower than page index");
   end
   if (VSID_W < HASH_W) begin : g_bad_vsid
      $error("segment identifier narrower than hash");
   end

   logic [HASH_W-1:0] raw;

   for (genvar b = 0; b < HASH_W; b++) begin : g_bit
      if (b < PIDX_W) begin : g_mix
         assign raw[b] = vsid[b] ^ pidx[b];
      end else begin : g_pass
         assign raw[b] = vsid[b];
      end
   end

   assign hash = raw ^ {HASH_W{secondary}};
endmodule

// File: rtl/pteg_addr_gen.sv
module pteg_addr_gen #(
   parameter int unsigned PA_W        = 32,
   parameter int unsigned HASH_W      = 19,
   parameter int unsigned IDX_W       = 3,
   parameter int unsigned ENTRY_SHIFT = 3
) (
   input  logic [PA_W-1:0]   base,
   input  logic [HASH_W-1:0] mask,
   input  logic [HASH_W-1:0] hash,
   input  logic [IDX_W-1:0]  idx,
   output logic [PA_W-1:0]   addr
);
   localparam int unsigned GROUP_SHIFT = IDX_W + ENTRY_SHIFT;

   if (HASH_W + GROUP_SHIFT > PA_W) begin : g_bad_pa
      $error("address too narrow for hash and group offset");
   end

   logic [PA_W-1:0] grp_off;
   logic [PA_W-1:0] ent_off;

   always_comb begin
      grp_off = '0;
      grp_off[GROUP_SHIFT +: HASH_W] = hash & mask;
      ent_off = '0;
      ent_off[ENTRY_SHIFT +: IDX_W]  = idx;
   end

   assign addr = base | grp_off | ent_off;
endmodule

// File: rtl/pteg_match.sv
module pteg_match #(
   parameter int unsigned ENTRY_W = 64,
   parameter int unsigned VSID_W  = 24,
   parameter int unsigned API_W   = 6,
   parameter int unsigned RPN_W   = 20
) (
   input  logic [ENTRY_W-1:0] entry,
   input  logic [VSID_W-1:0]  vsid,
   input  logic [API_W-1:0]   api,
   input  logic               pass,
   output logic               match,
   output logic [RPN_W-1:0]   rpn
);
   localparam int unsigned V_BIT    = ENTRY_W - 1;
   localparam int unsigned VSID_TOP = V_BIT - 1;
   localparam int unsigned HSEL_BIT = VSID_TOP - VSID_W;
   localparam int unsigned API_TOP  = HSEL_BIT - 1;
   localparam int unsigned RPN_TOP  = API_TOP - API_W;

   if (1 + VSID_W + 1 + API_W + RPN_W > ENTRY_W) begin : g_bad_entry
      $error("entry fields do not fit");
   end

   logic vsid_eq, api_eq;
   assign vsid_eq = entry[VSID_TOP -: VSID_W] == vsid;
   assign api_eq  = entry[API_TOP -: API_W] == api;
   assign match   = entry[V_BIT] & (entry[HSEL_BIT] == pass) & vsid_eq & api_eq;
   assign rpn     = entry[RPN_TOP -: RPN_W];
endmodule

// File: rtl/pteg_walker.sv
module pteg_walker
   import pteg_walker_pkg::*;
#(
   parameter int unsigned PA_W    = 32,
   parameter int unsigned VSID_W  = 24,
   parameter int unsigned PIDX_W  = 16,
   parameter int unsigned HASH_W  = 19,
   parameter int unsigned API_W   = 6,
   parameter int unsigned RPN_W   = 20,
   parameter int unsigned ENTRIES = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [VSID_W-1:0]   req_vsid,
   input  logic [PIDX_W-1:0]   req_pidx,
   input  logic [PA_W-1:0]     tbl_base,
   input  logic [HASH_W-1:0]   tbl_mask,
   output logic                busy,
   output logic                rd_req,
   output logic [PA_W-1:0]     rd_addr,
   input  logic                rd_rsp_valid,
   input  logic [ENTRY_W-1:0]  rd_rsp_data,
   output logic                done,
   output logic                hit,
   output logic [RPN_W-1:0]    hit_rpn
);
   localparam int unsigned IDX_W    = $clog2(ENTRIES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("entries per group must be a power of two");
   end
   if (API_W > PIDX_W) begin : g_bad_api
      $error("abbreviated index wider than page index");
   end

   walk_state_t          state_q;
   logic [VSID_W-1:0]    vsid_q;
   logic [PIDX_W-1:0]    pidx_q;
   logic [PA_W-1:0]      base_q;
   logic [HASH_W-1:0]    mask_q;
   logic                 pass_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 done_q, hit_q;
   logic [RPN_W-1:0]     rpn_q;

   logic [HASH_W-1:0]    hash;
   logic                 ent_match;
   logic [RPN_W-1:0]     ent_rpn;

   pteg_hash #(
      .VSID_W (VSID_W),
      .PIDX_W (PIDX_W),
      .HASH_W (HASH_W)
   ) u_hash (
      .vsid      (vsid_q),
      .pidx      (pidx_q),
      .secondary (pass_q),
      .hash      (hash)
   );

   pteg_addr_gen #(
      .PA_W        (PA_W),
      .HASH_W      (HASH_W),
      .IDX_W       (IDX_W),
      .ENTRY_SHIFT (ENTRY_SHIFT)
   ) u_addr (
      .base (base_q),
      .mask (mask_q),
      .hash (hash),
      .idx  (idx_q),
      .addr (rd_addr)
   );

   pteg_match #(
      .ENTRY_W (ENTRY_W),
      .VSID_W  (VSID_W),
      .API_W   (API_W),
      .RPN_W   (RPN_W)
   ) u_match (
      .entry (rd_rsp_data),
      .vsid  (vsid_q),
      .api   (pidx_q[PIDX_W-1 -: API_W]),
      .pass  (pass_q),
      .match (ent_match),
      .rpn   (ent_rpn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= WS_IDLE;
         vsid_q  <= '0;
         pidx_q  <= '0;
         base_q  <= '0;
         mask_q  <= '0;
         pass_q  <= 1'b0;
         idx_q   <= '0;
         done_q  <= 1'b0;
         hit_q   <= 1'b0;
         rpn_q   <= '0;
      end else begin
         done_q <= 1'b0;
         hit_q  <= 1'b0;
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  vsid_q  <= req_vsid;
                  pidx_q  <= req_pidx;
                  base_q  <= tbl_base;
                  mask_q  <= tbl_mask;
                  pass_q  <= 1'b0;
                  idx_q   <= '0;
                  state_q <= WS_ISSUE;
               end
            end
            WS_ISSUE: state_q <= WS_WAIT;
            WS_WAIT: begin
               if (rd_rsp_valid) begin
                  if (ent_match) begin
                     done_q  <= 1'b1;
                     hit_q   <= 1'b1;
                     rpn_q   <= ent_rpn;
                     state_q <= WS_IDLE;
                  end else if (idx_q != LAST_IDX) begin
                     idx_q   <= idx_q + 1'b1;
                     state_q <= WS_ISSUE;
                  end else if (!pass_q) begin
                     pass_q  <= 1'b1;
                     idx_q   <= '0;
                     state_q <= WS_ISSUE;
                  end else begin
                     done_q  <= 1'b1;
                     state_q <= WS_IDLE;
                  end
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign busy    = state_q != WS_IDLE;
   assign rd_req  = state_q == WS_ISSUE;
   assign done    = done_q;
   assign hit     = hit_q;
   assign hit_rpn = rpn_q;
endmodule

// File: rtl/pteg_walker_checker.sv
module pteg_walker_checker (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic rd_req,
   input logic rd_rsp_valid,
   input logic done,
   input logic hit
);
   p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   p_read_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> busy);

   p_start_from_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   p_done_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rd_rsp_valid));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_idle_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_hit_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> done);
endmodule

bind pteg_walker pteg_walker_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .busy         (busy),
   .rd_req       (rd_req),
   .rd_rsp_valid (rd_rsp_valid),
   .done         (done),
   .hit          (hit)
);

// File: tb/pteg_walker_test.sv
module pteg_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [23:0] req_vsid = '0;
   logic [15:0] req_pidx = '0;
   logic [31:0] tbl_base = '0;
   logic [18:0] tbl_mask = '0;
   logic        busy, rd_req, done, hit;
   logic [31:0] rd_addr;
   logic        rd_rsp_valid = 1'b0;
   logic [63:0] rd_rsp_data = '0;
   logic [19:0] hit_rpn;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pteg_walker uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vsid(req_vsid),
      .req_pidx(req_pidx), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
      .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
      .done(done), .hit(hit), .hit_rpn(hit_rpn)
   );

   // memory model
   logic [63:0] mem [longint];
   logic [31:0] exp_q [$];
   int          exp_left = 0;
   logic        exp_hit = 1'b0;
   logic [19:0] exp_rpn = '0;
   int          outstanding = 0;
   int          rd_count = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] entry(input bit v, input logic [23:0] vs, input bit hs,
                                         input logic [5:0] api, input logic [19:0] rpn);
      return {v, vs, hs, api, rpn, 12'h0};
   endfunction

   function automatic logic [63:0] peek(input logic [31:0] a);
      if (mem.exists(longint'(a))) return mem[longint'(a)];
      return 64'h0;
   endfunction

   // R1 hash: low 19 segment bits XOR zero-extended index, complemented for pass 1
   function automatic logic [18:0] ref_hash(input logic [23:0] vs, input logic [15:0] pi, input bit sec);
      logic [18:0] h;
      h = vs[18:0] ^ {3'b000, pi};
      return sec ? ~h : h;
   endfunction

   // R2 address
   function automatic logic [31:0] ref_addr(input logic [31:0] b, input logic [18:0] m,
                                            input logic [18:0] h, input int i);
      return b | (32'(h & m) << 6) | (32'(i) << 3);
   endfunction

   // memory responder: latency 1..3 cycles
   always @(negedge clk) begin
      logic        fire;
      logic [63:0] d;
      fire = 1'b0;
      d    = '0;
      if (rsp_pend) begin
         rsp_cnt--;
         if (rsp_cnt == 0) begin
            fire = 1'b1;
            d = rsp_data_q;
            rsp_pend = 1'b0;
         end
      end
      if (rd_req) begin
         rsp_pend   = 1'b1;
         rsp_cnt    = 1 + (rd_count % 3);
         rsp_data_q = peek(rd_addr);
      end
      #1;
      rd_rsp_valid <= fire;
      rd_rsp_data  <= fire ? d : 64'hDEAD_BEEF_0BAD_F00D;
   end
   logic        rsp_pend = 1'b0;
   int          rsp_cnt = 0;
   logic [63:0] rsp_data_q = '0;

   // cycle-by-cycle monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_rsp_valid) begin
            outstanding--;
            exp_left--;
            if (exp_left == 0) begin
               check(done === 1'b1, "R10 done after final response", done, 1);
               if (done) begin
                  check(hit === exp_hit, "R5/R7 hit flag", hit, exp_hit);
                  if (exp_hit) check(hit_rpn === exp_rpn, "R5 page number", hit_rpn, exp_rpn);
                  check(busy === 1'b0, "R10 busy drops with done", busy, 0);
               end
            end else begin
               check(done === 1'b0, "R10 early done", done, 0);
            end
         end else if (done) begin
            check(1'b0, "R10 done without response", done, 0);
         end
         if (rd_req) begin
            check(outstanding == 0, "R3 read while one outstanding", outstanding, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R3/R8 unexpected read", rd_addr, 0);
            end else begin
               logic [31:0] ea;
               ea = exp_q.pop_front();
               check(rd_addr === ea, "R1/R2/R3/R6 read address", rd_addr, ea);
            end
            outstanding++;
            rd_count++;
         end
      end
   end

   // build the expected read trace (R4 match rule, R6 second pass, R7 miss)
   task automatic plan(input logic [23:0] vs, input logic [15:0] pi,
                       input logic [31:0] b, input logic [18:0] m);
      bit found;
      found = 1'b0;
      exp_hit = 1'b0;
      exp_left = 0;
      for (int p = 0; p < 2 && !found; p++) begin
         for (int i = 0; i < 8 && !found; i++) begin
            logic [31:0] a;
            logic [63:0] e;
            a = ref_addr(b, m, ref_hash(vs, pi, p[0]), i);
            exp_q.push_back(a);
            exp_left++;
            e = peek(a);
            if (e[63] && e[38] == p[0] && e[62:39] == vs && e[37:32] == pi[15:10]) begin
               found = 1'b1;
               exp_hit = 1'b1;
               exp_rpn = e[31:12];
            end
         end
      end
   endtask

   task automatic search(input logic [23:0] vs, input logic [15:0] pi,
                         input logic [31:0] b, input logic [18:0] m, input bit poke_busy);
      int t;
      plan(vs, pi, b, m);
      @(negedge clk); #1;
      req_valid = 1'b1; req_vsid = vs; req_pidx = pi; tbl_base = b; tbl_mask = m;
      @(negedge clk);
      check(busy === 1'b1, "R8 busy after accept", busy, 1);
      #1;
      req_valid = 1'b0;
      if (poke_busy) begin
         @(negedge clk); #1;
         req_valid = 1'b1; req_vsid = ~vs; req_pidx = ~pi; tbl_base = 32'h0040_0000;
         @(negedge clk); @(negedge clk); #1;
         req_valid = 1'b0;
      end
      t = 0;
      while (exp_left > 0 && t < 500) begin
         @(negedge clk);
         t++;
      end
      check(t < 500, "watchdog search finished", t, 500);
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R3/R7 read count", exp_q.size(), 0);
      check(busy === 1'b0, "R8 idle after search", busy, 0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [23:0] vs;
      logic [15:0] pi;
      logic [31:0] b;
      logic [18:0] m;
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R9 busy at reset", busy, 0);
      check(rd_req === 1'b0, "R9 rd_req at reset", rd_req, 0);
      check(done === 1'b0, "R9 done at reset", done, 0);
      #1 rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // hit at entry 0 of primary group
      vs = 24'h12_3456; pi = 16'hA5C3; b = 32'h0100_0000; m = 19'h0_03FF;
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 0))] = entry(1, vs, 0, pi[15:10], 20'h1_1111);
      search(vs, pi, b, m, 0);

      // decoys before a match at entry 5 (R4)
      vs = 24'hAB_CDEF; pi = 16'h3210; b = 32'h0200_0000; m = 19'h0_0FFF;
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 0))] = entry(0, vs, 0, pi[15:10], 20'hBAD01);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 1))] = entry(1, vs, 1, pi[15:10], 20'hBAD02);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 2))] = entry(1, vs, 0, ~pi[15:10], 20'hBAD03);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 3))] = entry(1, vs ^ 24'h80_0000, 0, pi[15:10], 20'hBAD04);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 5))] = entry(1, vs, 0, pi[15:10], 20'h5_5555);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 7))] = entry(1, vs, 0, pi[15:10], 20'h7_7777);
      search(vs, pi, b, m, 0);   // R5: entry 5 wins over entry 7

      // secondary pass hit at entry 2 (R6), with a hash-select-1 decoy in primary
      vs = 24'h00_7A7A; pi = 16'hFFFF; b = 32'h0300_0000; m = 19'h0_3FFF;
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 0), 4))] = entry(1, vs, 1, pi[15:10], 20'hBAD05);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 1), 1))] = entry(1, vs, 0, pi[15:10], 20'hBAD06);
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 1), 2))] = entry(1, vs, 1, pi[15:10], 20'h2_2222);
      search(vs, pi, b, m, 0);

      // full miss, sixteen reads (R7), with a busy-time request that must be ignored (R8)
      vs = 24'h55_0001; pi = 16'h0042; b = 32'h0400_0000; m = 19'h7_FFFF;
      search(vs, pi, b, m, 1);

      // narrow mask: high hash bits dropped (R2)
      vs = 24'hFF_FFFF; pi = 16'h1234; b = 32'h0FFF_F000; m = 19'h0_003F;
      mem[longint'(ref_addr(b, m, ref_hash(vs, pi, 1), 7))] = entry(1, vs, 1, pi[15:10], 20'hF_EDCB);
      search(vs, pi, b, m, 0);

      // back-to-back after a miss with zero mask
      vs = 24'h01_0203; pi = 16'h0405; b = 32'h0500_0000; m = 19'h0;
      search(vs, pi, b, m, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule